// File: doc/BRIEF.md
# Multi-Preset Transmit Pattern Generator

This block produces one parallel transmit word per clock for each of several lanes, ready to feed a serializer. Each lane picks its own preset through a 5-bit select code: an all-zero word, three fixed 10-bit line-code symbols emitted as raw bit groups, four square waves at fixed fractions of the bit rate, and nine pseudo-random binary sequences of orders 5 to 31. The generator does no payload encoding and no serialization. It emits bit streams whose phase runs on unbroken from one word to the next.

Each lane has a dedicated engine for every preset. A rotating ring holds each fixed-period pattern, and an LFSR stepped a whole word per clock produces each PRBS. A per-lane enable advances the selected engine or freezes it. A new select value reseeds the lane at the next clock edge, and the new pattern begins on the following enabled word.

Top module: `txpat_gen`

## Requirements
- R1: Any clock edge that samples `rst` high clears every lane's word to zero and returns its stored selection to code 0. After that, a lane whose select stays at 0 emits zero words with no reload edge.
- R2: Code 0 gives all-zero words. Codes 17 to 31 are unused and also give all-zero words.
- R3: Bit W-1 of each word is the earliest bit in time and bit 0 the latest. Code 1 repeats the 10-bit group 1010101010. Code 3 repeats 0011111000. In both, the group phase carries on across word boundaries.
- R4: Code 2 alternates the two 10-bit groups 0011111010 and 1100000101, beginning with the first, so every 20 bits hold ten ones.
- R5: Codes 4, 5, 6 and 7 give square waves with periods of 16, 20, 40 and 50 bits. Each period is half ones followed by half zeros, starting with ones, and the phase carries on across words.
- R6: Codes 8 to 16 give PRBS of orders 5, 7, 9, 11, 13, 15, 21, 23 and 31. The polynomials are x^5+x^3+1, x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^13+x^12+x^2+x+1, x^15+x^14+1, x^21+x^19+1, x^23+x^18+1 and x^31+x^28+1. The register starts all ones. Each new bit is the XOR of the state bits at the tap exponents (exponent k means state bit k-1), and that bit is both emitted and shifted in at bit 0. Each word holds 32 consecutive bits.
- R7: No LFSR state is ever all zeros. As a result, no order-5 PRBS word is all zeros.
- R8: While a lane's enable is low, its word and its pattern state hold. When the enable returns high, the stream continues with the next unsent bits.
- R9: On the edge where a lane's select differs from its stored selection, the lane reseeds every engine and keeps its word unchanged. Its next enabled word is the first word of the new pattern.
- R10: Lanes are independent. Selecting, enabling or freezing one lane has no effect on another lane's stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | LANES | Per-lane advance enable |
| sel | input | LANES*5 | Per-lane preset code, lane g at bits [5g+4:5g] |
| tx_data | output | LANES*W | Per-lane registered word, lane g at bits [Wg+W-1:Wg] |

## Verification
Assertions check, on every cycle, the properties that relate one edge to the next. They cover a frozen lane or engine holding its state, a select change holding the word, code 0 and unused codes yielding zero, and every LFSR state staying nonzero. Only the bench can show that the emitted bits are the right ones. It does this by comparing whole multi-word runs against a bit-serial model of each preset. This covers the K28.5 alternation, square-wave and symbol phase across word boundaries, PRBS continuity after a freeze, and the isolation of one lane from another's traffic.

// File: rtl/txpat_pkg.sv
package txpat_pkg;
  localparam int SEL_W  = 5;
  localparam int N_RING = 7;
  localparam int N_PRBS = 9;

  localparam logic [SEL_W-1:0] SEL_ZERO  = '0;
  localparam logic [SEL_W-1:0] SEL_RING0 = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_PRBS0 = SEL_W'(1 + N_RING);
  localparam logic [SEL_W-1:0] SEL_LAST  = SEL_W'(N_RING + N_PRBS);

  // square wave: first half of the period ones, MSB transmitted first
  function automatic logic [63:0] half_ones(input int n);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < n / 2; i++) v[n-1-i] = 1'b1;
    return v;
  endfunction

  function automatic int ring_period(input int k);
    case (k)
      0: return 10;
      1: return 20;
      2: return 10;
      3: return 16;
      4: return 20;
      5: return 40;
      default: return 50;
    endcase
  endfunction

  function automatic logic [63:0] ring_bits(input int k);
    case (k)
      0: return 64'b1010101010;
      1: return 64'b0011111010_1100000101;
      2: return 64'b0011111000;
      default: return half_ones(ring_period(k));
    endcase
  endfunction

  function automatic int prbs_order(input int k);
    case (k)
      0: return 5;
      1: return 7;
      2: return 9;
      3: return 11;
      4: return 13;
      5: return 15;
      6: return 21;
      7: return 23;
      default: return 31;
    endcase
  endfunction

  // tap exponent e sets mask bit e-1
  function automatic logic [31:0] prbs_mask(input int k);
    case (k)
      0: return 32'h0000_0014;
      1: return 32'h0000_0060;
      2: return 32'h0000_0110;
      3: return 32'h0000_0500;
      4: return 32'h0000_1803;
      5: return 32'h0000_6000;
      6: return 32'h0014_0000;
      7: return 32'h0042_0000;
      default: return 32'h4800_0000;
    endcase
  endfunction
endpackage

// File: rtl/txpat_ring.sv
module txpat_ring #(
  parameter int          W    = 32,
  parameter int          P    = 10,
  parameter logic [63:0] BITS = 64'b1010101010
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] word_o
);
  localparam int ROT = W % P;

  logic [P-1:0] ring_q;
  logic [P-1:0] ring_rot;

  // ring_q[P-1] is the next bit to leave
  generate
    if (ROT == 0) begin : g_norot
      assign ring_rot = ring_q;
    end else begin : g_rot
      assign ring_rot = {ring_q[P-1-ROT:0], ring_q[P-1:P-ROT]};
    end
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign word_o[W-1-i] = ring_q[P-1-(i % P)];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (load)     ring_q <= BITS[P-1:0];
    else if (adv) ring_q <= ring_rot;
  end

  assert_ring_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(ring_q));
endmodule

// File: rtl/txpat_prbs.sv
module txpat_prbs #(
  parameter int          W     = 32,
  parameter int          ORDER = 7,
  parameter logic [31:0] MASK  = 32'h0000_0060
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] word_o
);
  localparam logic [ORDER-1:0] SEED = '1;
  localparam logic [ORDER-1:0] TAPS = MASK[ORDER-1:0];

  logic [ORDER-1:0] state_q;
  logic [ORDER-1:0] state_n;

  // W serial steps unrolled; the earliest bit lands in word_o[W-1]
  always_comb begin
    logic [ORDER-1:0] s;
    logic             fb;
    s = state_q;
    word_o = '0;
    for (int i = 0; i < W; i++) begin
      fb = ^(s & TAPS);
      word_o[W-1-i] = fb;
      s = {s[ORDER-2:0], fb};
    end
    state_n = s;
  end

  always_ff @(posedge clk) begin
    if (load)     state_q <= SEED;
    else if (adv) state_q <= state_n;
  end

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  assert_lfsr_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(state_q));
endmodule

// File: rtl/txpat_lane.sv
module txpat_lane
  import txpat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     word_o
);
  logic [SEL_W-1:0] sel_q;
  logic             chg;
  logic             load;
  logic [W-1:0]     ring_w [N_RING];
  logic [W-1:0]     prbs_w [N_PRBS];
  logic [W-1:0]     pick;
  logic [W-1:0]     word_q;

  assign chg  = (sel != sel_q);
  assign load = rst | chg;

  generate
    for (genvar k = 0; k < N_RING; k++) begin : g_ring
      localparam logic [SEL_W-1:0] CODE = SEL_RING0 + SEL_W'(k);
      txpat_ring #(
        .W   (W),
        .P   (ring_period(k)),
        .BITS(ring_bits(k))
      ) u_ring (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (en && !chg && (sel_q == CODE)),
        .word_o(ring_w[k])
      );
    end
    for (genvar k = 0; k < N_PRBS; k++) begin : g_prbs
      localparam logic [SEL_W-1:0] CODE = SEL_PRBS0 + SEL_W'(k);
      txpat_prbs #(
        .W    (W),
        .ORDER(prbs_order(k)),
        .MASK (prbs_mask(k))
      ) u_prbs (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (en && !chg && (sel_q == CODE)),
        .word_o(prbs_w[k])
      );
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int k = 0; k < N_RING; k++)
      if (sel_q == SEL_RING0 + SEL_W'(k)) pick = ring_w[k];
    for (int k = 0; k < N_PRBS; k++)
      if (sel_q == SEL_PRBS0 + SEL_W'(k)) pick = prbs_w[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_ZERO;
      word_q <= '0;
    end else begin
      sel_q <= sel;
      if (!chg && en) word_q <= pick;
    end
  end

  assign word_o = word_q;

  assert_reload_hold_R9: assert property (@(posedge clk) disable iff (rst)
    chg |=> $stable(word_q));
  assert_lane_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !chg) |=> $stable(word_q));
  assert_zero_codes_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !chg && (sel_q == SEL_ZERO || sel_q > SEL_LAST)) |=> (word_q == '0));
endmodule

// File: rtl/txpat_gen.sv
module txpat_gen
  import txpat_pkg::*;
#(
  parameter int LANES = 2,
  parameter int W     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       en,
  input  logic [LANES*SEL_W-1:0] sel,
  output logic [LANES*W-1:0]     tx_data
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      txpat_lane #(
        .W(W)
      ) u_lane (
        .clk   (clk),
        .rst   (rst),
        .en    (en[g]),
        .sel   (sel[g*SEL_W +: SEL_W]),
        .word_o(tx_data[g*W +: W])
      );
    end
  endgenerate
endmodule

// File: tb/sim_txpat_gen.sv
`timescale 1ns/1ps
module sim_txpat_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  en = '0;
  logic [4:0]  sel0 = '0;
  logic [4:0]  sel1 = '0;
  logic [63:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit l1_on = 1'b0;
  bit done = 1'b0;
  int unsigned mt [2];
  logic [30:0] ms [2];
  logic [4:0]  mcode [2];

  always #10 clk = ~clk;

  txpat_gen u0 (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .sel    ({sel1, sel0}),
    .tx_data(tx_data)
  );

  // {code, words, has_expected_first, expected_first}
  localparam logic [45:0] VEC [18] = '{
    {5'd1,  8'd6, 1'b1, 32'hAAAAAAAA},
    {5'd2,  8'd6, 1'b1, 32'h3EB053EB},
    {5'd3,  8'd6, 1'b1, 32'h3E0F83E0},
    {5'd4,  8'd6, 1'b1, 32'hFF00FF00},
    {5'd5,  8'd6, 1'b1, 32'hFFC00FFC},
    {5'd6,  8'd6, 1'b1, 32'hFFFFF000},
    {5'd7,  8'd8, 1'b1, 32'hFFFFFF80},
    {5'd8,  8'd8, 1'b0, 32'h0},
    {5'd9,  8'd8, 1'b0, 32'h0},
    {5'd10, 8'd8, 1'b0, 32'h0},
    {5'd11, 8'd8, 1'b0, 32'h0},
    {5'd12, 8'd8, 1'b0, 32'h0},
    {5'd13, 8'd8, 1'b0, 32'h0},
    {5'd14, 8'd8, 1'b0, 32'h0},
    {5'd15, 8'd8, 1'b0, 32'h0},
    {5'd16, 8'd8, 1'b0, 32'h0},
    {5'd0,  8'd4, 1'b1, 32'h0},
    {5'd25, 8'd4, 1'b1, 32'h0}
  };

  function automatic int b_period(input logic [4:0] c);
    case (c)
      5'd1, 5'd3: return 10;
      5'd2, 5'd5: return 20;
      5'd4:       return 16;
      5'd6:       return 40;
      default:    return 50;
    endcase
  endfunction

  function automatic logic [63:0] b_bits(input logic [4:0] c);
    case (c)
      5'd1: return 64'b1010101010;
      5'd2: return 64'b00111110101100000101;
      5'd3: return 64'b0011111000;
      5'd4: return 64'hFF00;
      5'd5: return 64'hFFC00;
      5'd6: return 64'hFFFFF00000;
      default: return 64'h3FFFFFE000000;
    endcase
  endfunction

  function automatic int b_order(input logic [4:0] c);
    case (c)
      5'd8:  return 5;
      5'd9:  return 7;
      5'd10: return 9;
      5'd11: return 11;
      5'd12: return 13;
      5'd13: return 15;
      5'd14: return 21;
      5'd15: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic logic [30:0] b_mask(input logic [4:0] c);
    case (c)
      5'd8:  return 31'h14;
      5'd9:  return 31'h60;
      5'd10: return 31'h110;
      5'd11: return 31'h500;
      5'd12: return 31'h1803;
      5'd13: return 31'h6000;
      5'd14: return 31'h140000;
      5'd15: return 31'h420000;
      default: return 31'h48000000;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] c);
    if (c == 5'd1 || c == 5'd3) return "R3";
    if (c == 5'd2) return "R4";
    if (c >= 5'd4 && c <= 5'd7) return "R5";
    if (c >= 5'd8 && c <= 5'd16) return "R6";
    return "R2";
  endfunction

  task automatic model_reset(input int l, input logic [4:0] c);
    mcode[l] = c;
    mt[l] = 0;
    ms[l] = '1;
  endtask

  task automatic model_word(input int l, output logic [31:0] w);
    logic [4:0]  c;
    logic [63:0] bits;
    logic [30:0] om;
    logic        b;
    int          p;
    c = mcode[l];
    w = '0;
    for (int i = 0; i < 32; i++) begin
      if (c >= 5'd1 && c <= 5'd7) begin
        p = b_period(c);
        bits = b_bits(c);
        b = bits[p-1-int'(mt[l] % p)];
        mt[l] = mt[l] + 1;
      end else if (c >= 5'd8 && c <= 5'd16) begin
        om = 31'((64'd1 << b_order(c)) - 64'd1);
        b = ^(ms[l] & b_mask(c));
        ms[l] = ((ms[l] << 1) | 31'(b)) & om;
      end else begin
        b = 1'b0;
      end
      w[31-i] = b;
    end
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] w;
    @(posedge clk);
    #1;
    if (l1_on) begin
      model_word(1, w);
      chk("R10", tx_data[63:32], w);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0]  c;
    int          n;
    bit          he;
    logic [31:0] ex;
    logic [31:0] prev;
    logic [31:0] w;
    logic [31:0] hold;

    // R1: reset state
    repeat (3) tick();
    chk("R1", tx_data[31:0], 32'h0);
    chk("R1", tx_data[63:32], 32'h0);
    rst = 1'b0;

    // lane 1 runs PRBS7 throughout, checked on every tick (R10)
    sel1 = 5'd9;
    en[1] = 1'b1;
    tick();
    chk("R9", tx_data[63:32], 32'h0);
    model_reset(1, 5'd9);
    l1_on = 1'b1;

    for (int v = 0; v < 18; v++) begin
      c  = VEC[v][45:41];
      n  = int'(VEC[v][40:33]);
      he = VEC[v][32];
      ex = VEC[v][31:0];
      prev = tx_data[31:0];
      sel0 = c;
      en[0] = 1'b1;
      tick();
      chk("R9", tx_data[31:0], prev);
      model_reset(0, c);
      for (int j = 0; j < n; j++) begin
        tick();
        model_word(0, w);
        chk(req_of(c), tx_data[31:0], w);
        if (j == 0 && he) chk(req_of(c), tx_data[31:0], ex);
      end
    end

    // R7: order-5 PRBS never yields an all-zero word
    sel0 = 5'd8;
    tick();
    model_reset(0, 5'd8);
    for (int j = 0; j < 40; j++) begin
      tick();
      model_word(0, w);
      chk("R6", tx_data[31:0], w);
      checks++;
      if (tx_data[31:0] == 32'h0) begin
        errors++;
        $display("FAIL R7 act=%h exp=nonzero", tx_data[31:0]);
      end
    end

    // R8: freeze and resume on PRBS31, lane 1 keeps running (R10)
    sel0 = 5'd16;
    tick();
    model_reset(0, 5'd16);
    for (int j = 0; j < 3; j++) begin
      tick();
      model_word(0, w);
      chk("R6", tx_data[31:0], w);
    end
    en[0] = 1'b0;
    hold = tx_data[31:0];
    for (int j = 0; j < 3; j++) begin
      tick();
      chk("R8", tx_data[31:0], hold);
    end
    en[0] = 1'b1;
    tick();
    model_word(0, w);
    chk("R8", tx_data[31:0], w);

    // R1: reset mid-run clears both lanes, then code 0 needs no reload
    l1_on = 1'b0;
    rst = 1'b1;
    tick();
    chk("R1", tx_data[31:0], 32'h0);
    chk("R1", tx_data[63:32], 32'h0);
    rst = 1'b0;
    sel0 = 5'd0;
    tick();
    chk("R1", tx_data[31:0], 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule